// File: doc/BRIEF.md
# Shared Interrupt Source Vector

Several serial ports may share one interrupt request line. This block gathers each port's request and drives the shared request output. It also publishes a registered 8-bit word in which each bit stands for one port. When the shared line fires, the handler reads that word to find which ports need service, so it does not have to poll every port in turn.

Each bit of the word can be set to assert high or low. One configuration input selects this polarity. The shared request output is always active high and does not depend on that choice. Bit positions for ports that are not built always read as the inactive level. Software reads the word by pulsing a single read strobe. The strobe copies the current vector into a read-data register and changes nothing else.

Top module: `shared_irq_vector`

## Requirements
- R1: Bit i of the vector belongs to port number i+1, carried on `port_req[i]`. Bit 0 is the lowest-numbered port and bit 7 is port 8.
- R2: With `pol_low` = 0, a vector bit reads 1 while its port requests service and 0 otherwise.
- R3: With `pol_low` = 1, a vector bit reads 0 while its port requests service and 1 otherwise.
- R4: `irq_out` is 1 exactly when at least one built port was requesting at the previous rising clock edge. This holds for both polarity settings.
- R5: `vec_out` and `irq_out` are registered. Each reflects `port_req` and `pol_low` as sampled at the previous rising edge.
- R6: Vector bits at positions NUM_PORTS and above always read the inactive level for the sampled polarity: 0 when active high, 1 when active low.
- R7: A rising edge with `rd_stb` = 1 loads `rd_data` with the value `vec_out` held just before that edge. Without the strobe, `rd_data` keeps its value.
- R8: Pulsing `rd_stb` leaves `vec_out` and `irq_out` unchanged. A pending request stays visible after it is read.
- R9: A rising edge with `rst` = 1 clears `irq_out` and `rd_data` to 0. It sets `vec_out` to the inactive level for `pol_low`: 0xFF when active low, 0x00 when active high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| port_req | input | NUM_PORTS | Request level of each port, bit i = port i+1 |
| pol_low | input | 1 | 1 selects active-low vector bits, 0 active-high |
| rd_stb | input | 1 | Read strobe, captures the vector into rd_data |
| irq_out | output | 1 | Shared interrupt request, active high |
| vec_out | output | 8 | Registered source vector |
| rd_data | output | 8 | Vector value captured by the last read strobe |

## Verification
The bench builds two copies of the block from the same stimulus. One uses the default eight ports and the other uses six. The full-width copy reaches the mapping of every bit position, up to and including port 8. The six-port copy places two unbuilt positions in the upper bits, which exposes their inactive level under both polarities. The bench runs one-hot walks and then random request patterns with random polarity and read pulses. This shows that a polarity flip reverses each port's bit but leaves the shared request line alone.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    localparam int VEC_W = 8;

    typedef logic [VEC_W-1:0] vec_t;

    typedef enum logic {
        POL_HIGH = 1'b0,
        POL_LOW  = 1'b1
    } pol_e;

    typedef struct packed {
        logic irq;
        vec_t vec;
    } status_t;

    // Level a bit shows when its port is quiet.
    function automatic vec_t idle_word(pol_e p);
        return (p == POL_LOW) ? {VEC_W{1'b1}} : {VEC_W{1'b0}};
    endfunction

    // Convert active-high request bits to the selected bit polarity.
    function automatic vec_t apply_pol(vec_t act, pol_e p);
        return (p == POL_LOW) ? ~act : act;
    endfunction
endpackage

// File: rtl/irqv_widen.sv
module irqv_widen
    import irqv_pkg::*;
#(
    parameter int NUM_PORTS = 8
) (
    input  logic [NUM_PORTS-1:0] port_req,
    output vec_t                 req_w
);
    // Built ports keep their positions; unbuilt ones are tied off as quiet.
    for (genvar i = 0; i < VEC_W; i++) begin : g_bit
        if (i < NUM_PORTS) begin : g_used
            assign req_w[i] = port_req[i];
        end else begin : g_tied
            assign req_w[i] = 1'b0;
        end
    end
endmodule

// File: rtl/irqv_encode.sv
module irqv_encode
    import irqv_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  vec_t    req_w,
    input  pol_e    pol,
    output status_t stat_q
);
    status_t stat_d;

    always_comb begin
        stat_d.irq = |req_w;
        stat_d.vec = apply_pol(req_w, pol);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q.irq <= 1'b0;
            stat_q.vec <= idle_word(pol);
        end else begin
            stat_q <= stat_d;
        end
    end
endmodule

// File: rtl/irqv_read.sv
module irqv_read
    import irqv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rd_stb,
    input  vec_t vec_q,
    output vec_t rd_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_stb) begin
            rd_q <= vec_q;
        end
    end
endmodule

// File: rtl/shared_irq_vector.sv
module shared_irq_vector
    import irqv_pkg::*;
#(
    parameter int NUM_PORTS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PORTS-1:0] port_req,
    input  logic                 pol_low,
    input  logic                 rd_stb,
    output logic                 irq_out,
    output logic [VEC_W-1:0]     vec_out,
    output logic [VEC_W-1:0]     rd_data
);
    vec_t    req_w;
    status_t stat_q;
    vec_t    rd_q;
    pol_e    pol;

    assign pol = pol_e'(pol_low);

    irqv_widen #(.NUM_PORTS(NUM_PORTS)) u_widen (
        .port_req (port_req),
        .req_w    (req_w)
    );

    irqv_encode u_encode (
        .clk    (clk),
        .rst    (rst),
        .req_w  (req_w),
        .pol    (pol),
        .stat_q (stat_q)
    );

    irqv_read u_read (
        .clk    (clk),
        .rst    (rst),
        .rd_stb (rd_stb),
        .vec_q  (stat_q.vec),
        .rd_q   (rd_q)
    );

    assign irq_out = stat_q.irq;
    assign vec_out = stat_q.vec;
    assign rd_data = rd_q;
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
    parameter int NUM_PORTS = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_PORTS-1:0] port_req,
    input logic                 pol_low,
    input logic                 rd_stb,
    input logic                 irq_out,
    input logic [7:0]           vec_out,
    input logic [7:0]           rd_data
);
    AST_IRQ_ANY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_out == (|$past(port_req)))); // R4

    AST_VEC_HIGH: assert property (@(posedge clk) disable iff (rst)
        !pol_low |=> (vec_out[NUM_PORTS-1:0] == $past(port_req))); // R2

    AST_VEC_LOW: assert property (@(posedge clk) disable iff (rst)
        pol_low |=> (vec_out[NUM_PORTS-1:0] == ~$past(port_req))); // R3

    AST_RD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> (rd_data == $past(vec_out))); // R7

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> $stable(rd_data)); // R7

    if (NUM_PORTS < 8) begin : g_unused
        AST_UNUSED_IDLE: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (vec_out[7:NUM_PORTS] == {(8-NUM_PORTS){$past(pol_low)}})); // R6
    end
endmodule

bind shared_irq_vector irqv_checker #(.NUM_PORTS(NUM_PORTS)) u_irqv_chk (
    .clk      (clk),
    .rst      (rst),
    .port_req (port_req),
    .pol_low  (pol_low),
    .rd_stb   (rd_stb),
    .irq_out  (irq_out),
    .vec_out  (vec_out),
    .rd_data  (rd_data)
);

// File: tb/shared_irq_vector_bench.sv
module shared_irq_vector_bench;
    localparam int NARROW = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req = '0;
    logic       pol_low = 1'b1;
    logic       rd_stb = 1'b0;

    logic       irq_w, irq_n;
    logic [7:0] vec_w, vec_n, rd_w, rd_n;
    logic [7:0] exp_rd_w, exp_rd_n;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    shared_irq_vector #(.NUM_PORTS(8)) u_shared_irq_vector (
        .clk(clk), .rst(rst), .port_req(req), .pol_low(pol_low), .rd_stb(rd_stb),
        .irq_out(irq_w), .vec_out(vec_w), .rd_data(rd_w)
    );

    shared_irq_vector #(.NUM_PORTS(NARROW)) u_shared_irq_vector_narrow (
        .clk(clk), .rst(rst), .port_req(req[NARROW-1:0]), .pol_low(pol_low), .rd_stb(rd_stb),
        .irq_out(irq_n), .vec_out(vec_n), .rd_data(rd_n)
    );

    function automatic logic [7:0] model_vec(logic [7:0] r, int n, logic pl);
        logic [7:0] v;
        for (int i = 0; i < 8; i++) begin
            logic a;
            a = (i < n) ? r[i] : 1'b0;
            v[i] = pl ? ~a : a;
        end
        return v;
    endfunction

    function automatic logic model_irq(logic [7:0] r, int n);
        logic a = 1'b0;
        for (int i = 0; i < n; i++) a |= r[i];
        return a;
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check_outputs(string tag);
        chk({tag, " vec wide"},   vec_w, model_vec(req, 8, pol_low));
        chk({tag, " vec narrow"}, vec_n, model_vec(req, NARROW, pol_low));
        chk({tag, " irq wide"},   {7'd0, irq_w}, {7'd0, model_irq(req, 8)});
        chk({tag, " irq narrow"}, {7'd0, irq_n}, {7'd0, model_irq(req, NARROW)});
    endtask

    task automatic do_read(string tag);
        rd_stb = 1'b1;
        exp_rd_w = vec_w;
        exp_rd_n = vec_n;
        tick();
        rd_stb = 1'b0;
        chk({tag, " R7 rd wide"},   rd_w, exp_rd_w);
        chk({tag, " R7 rd narrow"}, rd_n, exp_rd_n);
        check_outputs({tag, " R8 after read"});
    endtask

    initial begin
        #(4 * 150000);
        mismatched++;
        $display("FAIL watchdog actual=timeout expected=finish");
        if (!done) $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R9 reset state under both polarities
        req = 8'hA5;
        tick(); tick();
        chk("R9 vec low",   vec_w, 8'hFF);
        chk("R9 irq",       {7'd0, irq_w}, 8'h00);
        chk("R9 rd",        rd_w, 8'h00);
        pol_low = 1'b0;
        tick();
        chk("R9 vec high",  vec_w, 8'h00);
        chk("R9 vec high narrow", vec_n, 8'h00);
        rst = 1'b0;
        exp_rd_w = '0;
        exp_rd_n = '0;

        // R1 R2: one-hot walk, active high
        for (int i = 0; i < 8; i++) begin
            req = 8'h01 << i;
            tick();
            check_outputs("R1 R2 R5 walk high");
        end
        // R3: one-hot walk, active low
        pol_low = 1'b1;
        for (int i = 0; i < 8; i++) begin
            req = 8'h01 << i;
            tick();
            check_outputs("R1 R3 walk low");
        end
        // R6 unbuilt positions with all requests, both polarities
        req = 8'hFF;
        tick();
        chk("R6 narrow low", vec_n, 8'hC0);
        pol_low = 1'b0;
        tick();
        chk("R6 narrow high", vec_n, 8'h3F);
        // R4 no request in either polarity, and a request only on unbuilt port
        req = 8'h00;
        tick();
        check_outputs("R4 idle high");
        pol_low = 1'b1;
        tick();
        check_outputs("R4 idle low");
        req = 8'h80;
        tick();
        chk("R4 R6 narrow irq unbuilt", {7'd0, irq_n}, 8'h00);
        chk("R4 wide irq port8", {7'd0, irq_w}, 8'h01);
        // R5 latency: output still old before the edge
        req = 8'h02;
        #1;
        chk("R5 before edge", vec_w, 8'h7F);
        tick();
        chk("R5 after edge", vec_w, 8'hFD);
        // R7 R8 read and hold
        do_read("dir");
        req = 8'h10;
        tick(); tick();
        chk("R7 hold wide", rd_w, exp_rd_w);
        chk("R7 hold narrow", rd_n, exp_rd_n);

        // random phase
        for (int k = 0; k < 400; k++) begin
            req = 8'($urandom);
            pol_low = 1'($urandom);
            tick();
            check_outputs("R2 R3 R4 rand");
            if (($urandom % 2) == 1) begin
                do_read("rand");
            end else begin
                tick();
                chk("R7 rand hold wide", rd_w, exp_rd_w);
                chk("R7 rand hold narrow", rd_n, exp_rd_n);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule